// File: doc/BRIEF.md
# CAN Controller Control Register

This block is the 16-bit control and command register of a CAN controller. A host reaches it through a single-register write port with two byte enables. Its contents are always visible on a combinational read bus. The stored fields drive the controller's mode selects:

- initialisation request
- loopback
- message byte order
- basic mode
- bus-error interrupt enable
- sleep
- pin enable
- time stamp prescaler
- listen-only

Most of these selects are protected. A write to a protected field takes effect only while the controller's status input reports that it is in reset/initialisation mode. At any other time the write is dropped without notice. The initialisation request and the pin enable can be written at any time.

Two bits in the high byte are commands, not stored state. Writing 1 to either one emits a single-cycle strobe in the cycle after the write. One strobe clears the time stamp counter. The other clears the receive and transmit error counters, which returns the controller from bus-off. Both command bits always read back as 0. A transmit-inhibit output follows the listen-only select so that transmit requests can be blocked.

Top module: `canctl_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x0001: the initialisation request (bit 0) is 1 and every other bit is 0. Every mode output and both strobes are 0.
- R2: Bit 0 (initialisation request) can be written whenever the low byte is enabled, whatever the state of `reset_mode_sts`. It drives `reset_req` from the clock edge of the write.
- R3: Bit 6 (pin enable) can be written whenever the low byte is enabled, whatever the state of `reset_mode_sts`. It drives `pin_en`.
- R4: The protected fields are bit 1 loopback, bit 2 message byte order (1 = byte access), bit 3 basic mode, bit 4 bus-error interrupt enable, bit 5 sleep, bits 9:8 prescaler and bit 13 listen-only. They take a written value only when `reset_mode_sts` is 1 at the write edge. Otherwise they keep their previous value.
- R5: `be[0]` enables bits 7:0 and `be[1]` enables bits 15:8. A byte whose enable is 0 is left unchanged, and a write with `be` = 00 changes nothing.
- R6: When high-byte bit 10 is written as 1, `ts_clear_pulse` is high for exactly the one cycle after the write edge.
- R7: When high-byte bit 11 is written as 1, `ec_clear_pulse` is high for exactly the one cycle after the write edge. A command bit written through a disabled byte emits no strobe.
- R8: Command bits 10 and 11 always read back as 0.
- R9: Unassigned bits 7, 12, 14 and 15 always read back as 0, whatever value is written to them.
- R10: `tx_inhibit` is 1 exactly when the listen-only select (bit 13) is 1.
- R11: The prescaler field (bits 9:8) appears on `ts_prescale` as a 2-bit code: 0 = one bit time, 1 = 1/2, 2 = 1/4, 3 = 1/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request, sampled on the rising clock edge |
| be | input | 2 | Byte enables: bit 0 = low byte, bit 1 = high byte |
| wdata | input | 16 | Write data |
| reset_mode_sts | input | 1 | Controller reports reset/initialisation mode (from the status logic) |
| rd_data | output | 16 | Current register contents; command and unassigned bits read 0 |
| reset_req | output | 1 | Initialisation-mode request |
| loopback | output | 1 | Loopback select |
| msg_byte_order | output | 1 | Message order: 0 word access, 1 byte access |
| basic_mode | output | 1 | Basic mode select |
| buserr_irq_en | output | 1 | Bus-error interrupt enable |
| sleep_en | output | 1 | Sleep select |
| pin_en | output | 1 | CAN pin function enable |
| ts_prescale | output | 2 | Time stamp prescaler code |
| listen_only | output | 1 | Listen-only select |
| tx_inhibit | output | 1 | Blocks transmit requests while listen-only is set |
| ts_clear_pulse | output | 1 | One-cycle strobe that clears the time stamp counter |
| ec_clear_pulse | output | 1 | One-cycle strobe that clears both error counters |

## Verification
The assertions assume that `reset_mode_sts` and the write inputs are stable around each rising edge, because a write is judged against the status value present at that same edge. The bench drives every input on the falling edge and changes `reset_mode_sts` only between writes, never during one. It reads the outputs at the next falling edge, so a strobe and its write appear together in one sample. The same rule keeps the locked and unlocked cases separate.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
   localparam int unsigned REG_W  = 16;
   localparam int unsigned BYTE_W = 8;

   // field positions
   localparam int unsigned POS_RST_REQ  = 0;
   localparam int unsigned POS_LOOP     = 1;
   localparam int unsigned POS_ORDER    = 2;
   localparam int unsigned POS_BASIC    = 3;
   localparam int unsigned POS_BERR_EN  = 4;
   localparam int unsigned POS_SLEEP    = 5;
   localparam int unsigned POS_PIN      = 6;
   localparam int unsigned POS_PSC_LSB  = 8;
   localparam int unsigned PSC_W        = 2;
   localparam int unsigned POS_TS_CMD   = 10;
   localparam int unsigned POS_EC_CMD   = 11;
   localparam int unsigned POS_LISTEN   = 13;

   // bits held in flops
   localparam logic [REG_W-1:0] STORE_MASK = 16'h237F;
   // stored bits that need reset/initialisation mode to change
   localparam logic [REG_W-1:0] LOCK_MASK  = 16'h233E;
   // self-clearing command bits
   localparam logic [REG_W-1:0] CMD_MASK   = 16'h0C00;
   localparam logic [REG_W-1:0] RESET_VAL  = 16'h0001;

   typedef struct packed {
      logic             rst_req;
      logic             loopback;
      logic             byte_order;
      logic             basic;
      logic             berr_en;
      logic             sleep;
      logic             pin;
      logic [PSC_W-1:0] psc;
      logic             listen;
   } ctl_fields_t;
endpackage

// File: rtl/canctl_byte_wr.sv
module canctl_byte_wr #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NBYTES = DATA_W / BYTE_W
) (
   input  logic              wr_en,
   input  logic [NBYTES-1:0] be,
   output logic [DATA_W-1:0] bit_we
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign bit_we[b*BYTE_W +: BYTE_W] = {BYTE_W{wr_en & be[b]}};
   end
endmodule

// File: rtl/canctl_store.sv
module canctl_store #(
   parameter int unsigned        DATA_W     = 16,
   parameter logic [DATA_W-1:0]  STORE_MASK = '0,
   parameter logic [DATA_W-1:0]  LOCK_MASK  = '0,
   parameter logic [DATA_W-1:0]  RESET_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bit_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              unlocked,
   output logic [DATA_W-1:0] q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (STORE_MASK[i]) begin : g_ff
         logic allow;
         logic r;
         if (LOCK_MASK[i]) begin : g_lock
            assign allow = unlocked;
         end else begin : g_free
            assign allow = 1'b1;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= RESET_VAL[i];
            end else if (bit_we[i] && allow) begin
               r <= wdata[i];
            end
         end
         assign q[i] = r;
      end else begin : g_zero
         logic unused_in;
         assign unused_in = bit_we[i] ^ wdata[i];
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/canctl_cmd.sv
module canctl_cmd #(
   parameter int unsigned N_CMD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CMD-1:0] cmd_we,
   input  logic [N_CMD-1:0] cmd_val,
   output logic [N_CMD-1:0] strobe
);
   for (genvar k = 0; k < N_CMD; k++) begin : g_cmd
      logic s;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s <= 1'b0;
         end else begin
            s <= cmd_we[k] & cmd_val[k];
         end
      end
      assign strobe[k] = s;
   end
endmodule

// File: rtl/canctl_ctrl_reg.sv
module canctl_ctrl_reg
   import canctl_pkg::*;
#(
   parameter int unsigned DATA_W = REG_W,
   parameter int unsigned LANE_W = BYTE_W,
   localparam int unsigned NBYTES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        be,
   input  logic [15:0]       wdata,
   input  logic              reset_mode_sts,
   output logic [15:0]       rd_data,
   output logic              reset_req,
   output logic              loopback,
   output logic              msg_byte_order,
   output logic              basic_mode,
   output logic              buserr_irq_en,
   output logic              sleep_en,
   output logic              pin_en,
   output logic [1:0]        ts_prescale,
   output logic              listen_only,
   output logic              tx_inhibit,
   output logic              ts_clear_pulse,
   output logic              ec_clear_pulse
);
   if (DATA_W != 16) begin : g_bad_w
      $error("canctl_ctrl_reg: DATA_W must be 16");
   end
   if (NBYTES * LANE_W != DATA_W || NBYTES != 2) begin : g_bad_lane
      $error("canctl_ctrl_reg: lane width must split the register into two bytes");
   end
   if ((STORE_MASK & CMD_MASK) != '0 || (LOCK_MASK & ~STORE_MASK) != '0) begin : g_bad_mask
      $error("canctl_ctrl_reg: inconsistent field masks");
   end

   logic [DATA_W-1:0] bit_we;
   logic [DATA_W-1:0] stored;
   logic [1:0]        cmd_strb;
   ctl_fields_t       f;

   canctl_byte_wr #(.DATA_W(DATA_W), .BYTE_W(LANE_W)) u_bwr (
      .wr_en (wr_en),
      .be    (be),
      .bit_we(bit_we)
   );

   canctl_store #(
      .DATA_W    (DATA_W),
      .STORE_MASK(STORE_MASK),
      .LOCK_MASK (LOCK_MASK),
      .RESET_VAL (RESET_VAL)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_we  (bit_we),
      .wdata   (wdata),
      .unlocked(reset_mode_sts),
      .q       (stored)
   );

   canctl_cmd #(.N_CMD(2)) u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_we ({bit_we[POS_EC_CMD], bit_we[POS_TS_CMD]}),
      .cmd_val({wdata[POS_EC_CMD], wdata[POS_TS_CMD]}),
      .strobe (cmd_strb)
   );

   always_comb begin
      f.rst_req    = stored[POS_RST_REQ];
      f.loopback   = stored[POS_LOOP];
      f.byte_order = stored[POS_ORDER];
      f.basic      = stored[POS_BASIC];
      f.berr_en    = stored[POS_BERR_EN];
      f.sleep      = stored[POS_SLEEP];
      f.pin        = stored[POS_PIN];
      f.psc        = stored[POS_PSC_LSB +: PSC_W];
      f.listen     = stored[POS_LISTEN];
   end

   assign rd_data        = stored;
   assign reset_req      = f.rst_req;
   assign loopback       = f.loopback;
   assign msg_byte_order = f.byte_order;
   assign basic_mode     = f.basic;
   assign buserr_irq_en  = f.berr_en;
   assign sleep_en       = f.sleep;
   assign pin_en         = f.pin;
   assign ts_prescale    = f.psc;
   assign listen_only    = f.listen;
   assign tx_inhibit     = f.listen;
   assign ts_clear_pulse = cmd_strb[0];
   assign ec_clear_pulse = cmd_strb[1];
endmodule

// File: rtl/canctl_ctrl_reg_chk.sv
module canctl_ctrl_reg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [1:0]  be,
   input logic [15:0] wdata,
   input logic        reset_mode_sts,
   input logic [15:0] rd_data,
   input logic        reset_req,
   input logic        loopback,
   input logic        msg_byte_order,
   input logic        basic_mode,
   input logic        buserr_irq_en,
   input logic        sleep_en,
   input logic        pin_en,
   input logic [1:0]  ts_prescale,
   input logic        listen_only,
   input logic        tx_inhibit,
   input logic        ts_clear_pulse,
   input logic        ec_clear_pulse
);
   // R2
   rst_req_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[0]) |=> (reset_req == $past(wdata[0])));
   // R3
   pin_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[0]) |=> (pin_en == $past(wdata[6])));
   // R4
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reset_mode_sts) |=> $stable({loopback, msg_byte_order, basic_mode,
                                     buserr_irq_en, sleep_en, ts_prescale, listen_only}));
   // R5
   lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && be[1])) |=> $stable(rd_data[15:8]));
   // R6
   ts_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_clear_pulse |-> $past(wr_en && be[1] && wdata[10]));
   // R7
   ec_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ec_clear_pulse |-> $past(wr_en && be[1] && wdata[11]));
   // R8
   cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[11:10] == 2'b00);
   // R9
   spare_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & 16'hD080) == 16'h0000);
   // R10
   inhibit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_inhibit == rd_data[13]);
endmodule

bind canctl_ctrl_reg canctl_ctrl_reg_chk u_chk (.*);

// File: tb/canctl_ctrl_reg_tb.sv
module canctl_ctrl_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  be = 2'b00;
   logic [15:0] wdata = 16'h0000;
   logic        reset_mode_sts = 1'b0;
   logic [15:0] rd_data;
   logic        reset_req, loopback, msg_byte_order, basic_mode, buserr_irq_en;
   logic        sleep_en, pin_en, listen_only, tx_inhibit;
   logic        ts_clear_pulse, ec_clear_pulse;
   logic [1:0]  ts_prescale;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   canctl_ctrl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .be(be), .wdata(wdata),
      .reset_mode_sts(reset_mode_sts), .rd_data(rd_data), .reset_req(reset_req),
      .loopback(loopback), .msg_byte_order(msg_byte_order), .basic_mode(basic_mode),
      .buserr_irq_en(buserr_irq_en), .sleep_en(sleep_en), .pin_en(pin_en),
      .ts_prescale(ts_prescale), .listen_only(listen_only), .tx_inhibit(tx_inhibit),
      .ts_clear_pulse(ts_clear_pulse), .ec_clear_pulse(ec_clear_pulse)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   // write at one rising edge; returns at the following falling edge
   task automatic wr(input logic [1:0] b, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; be = b; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; be = 2'b00; wdata = 16'h0000;
   endtask

   task automatic t_reset;
      check("R1 rd_data", rd_data, 16'h0001);
      check("R1 outputs", {5'd0, reset_req, loopback, msg_byte_order, basic_mode,
                           buserr_irq_en, sleep_en, pin_en, ts_prescale, listen_only, tx_inhibit},
            16'h0400);
      check("R1 strobes", {14'd0, ts_clear_pulse, ec_clear_pulse}, 16'h0000);
   endtask

   task automatic t_rst_bit;
      reset_mode_sts = 1'b0;
      wr(2'b01, 16'h0000);
      check("R2 clear", {15'd0, reset_req}, 16'h0000);
      wr(2'b01, 16'h0001);
      check("R2 set", {15'd0, reset_req}, 16'h0001);
   endtask

   task automatic t_locked;
      reset_mode_sts = 1'b0;
      wr(2'b11, 16'hFFFF);
      check("R4 locked readback", rd_data, 16'h0041);
      check("R3 pin set while locked", {15'd0, pin_en}, 16'h0001);
      check("R4 protected outputs", {9'd0, loopback, msg_byte_order, basic_mode,
                                     buserr_irq_en, sleep_en, ts_prescale}, 16'h0000);
      check("R6 R7 strobes", {14'd0, ts_clear_pulse, ec_clear_pulse}, 16'h0003);
      @(negedge clk);
      check("R6 R7 strobe one cycle", {14'd0, ts_clear_pulse, ec_clear_pulse}, 16'h0000);
   endtask

   task automatic t_unlocked;
      reset_mode_sts = 1'b1;
      wr(2'b11, 16'h237E);
      check("R4 unlocked readback", rd_data, 16'h237E);
      check("R4 fields", {7'd0, loopback, msg_byte_order, basic_mode, buserr_irq_en,
                          sleep_en, pin_en, ts_prescale, listen_only}, 16'h01FF);
      check("R11 prescale 3", {14'd0, ts_prescale}, 16'h0003);
      reset_mode_sts = 1'b0;
      wr(2'b11, 16'h0000);
      check("R4 hold after lock", rd_data, 16'h233E);
      check("R3 pin cleared while locked", {15'd0, pin_en}, 16'h0000);
   endtask

   task automatic t_bytes;
      reset_mode_sts = 1'b1;
      wr(2'b01, 16'h0000);
      check("R5 low lane only", rd_data, 16'h2300);
      wr(2'b10, 16'h0000);
      check("R5 high lane only", rd_data, 16'h0000);
      wr(2'b00, 16'hFFFF);
      check("R5 no lane", rd_data, 16'h0000);
      wr(2'b10, 16'h0100);
      check("R11 prescale 1", {14'd0, ts_prescale}, 16'h0001);
      wr(2'b10, 16'h0200);
      check("R11 prescale 2", {14'd0, ts_prescale}, 16'h0002);
   endtask

   task automatic t_ts_cmd;
      wr(2'b10, 16'h0400);
      check("R6 ts strobe", {14'd0, ts_clear_pulse, ec_clear_pulse}, 16'h0002);
      check("R8 ts reads 0", rd_data, 16'h0000);
      @(negedge clk);
      check("R6 ts strobe ends", {15'd0, ts_clear_pulse}, 16'h0000);
      wr(2'b01, 16'h0400);
      check("R6 no strobe without lane", {15'd0, ts_clear_pulse}, 16'h0000);
   endtask

   task automatic t_ec_cmd;
      wr(2'b10, 16'h0800);
      check("R7 ec strobe", {14'd0, ts_clear_pulse, ec_clear_pulse}, 16'h0001);
      check("R8 ec reads 0", rd_data, 16'h0000);
      @(negedge clk);
      check("R7 ec strobe ends", {15'd0, ec_clear_pulse}, 16'h0000);
      wr(2'b01, 16'h0800);
      check("R7 no strobe without lane", {15'd0, ec_clear_pulse}, 16'h0000);
   endtask

   task automatic t_spare;
      reset_mode_sts = 1'b1;
      wr(2'b11, 16'hD080);
      check("R9 spare bits read 0", rd_data, 16'h0000);
   endtask

   task automatic t_listen;
      reset_mode_sts = 1'b1;
      wr(2'b10, 16'h2000);
      check("R10 inhibit on", {14'd0, listen_only, tx_inhibit}, 16'h0003);
      wr(2'b10, 16'h0000);
      check("R10 inhibit off", {14'd0, listen_only, tx_inhibit}, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rst_bit();
      t_locked();
      t_unlocked();
      t_bytes();
      t_ts_cmd();
      t_ec_cmd();
      t_spare();
      t_listen();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule